// File: doc/BRIEF.md
# Microcode image checksum validator

This block inspects one processor update image that arrives as a stream of 32-bit words, one word per cycle when `in_valid_i` is high, with `in_last_i` marking the final word. It never stalls the stream. It captures the header fields it needs and keeps two running 32-bit wrapping sums: one over the header plus payload, and one over the optional extended signature table that may follow the payload. While the table streams past, it cross-checks each table entry against the main header. It also tests whether a signature matches the processor identity presented on `cpu_sig_i` and `cpu_pf_i`.

One cycle after the final word, the block pulses `done_o` for exactly one cycle. With that pulse it gives a pass flag, a match flag and a 3-bit reason code. The block then starts again at once for the next image, so images may follow each other with no idle cycle between them. `hdr_type_i`, `cpu_sig_i` and `cpu_pf_i` must stay stable while an image is streaming.

Top module: `ucode_chk_top`

## Requirements
- R1: `done_o` is high for exactly the one cycle after each accepted word that has `in_last_i` set. In every other cycle `done_o`, `pass_o` and `match_o` are 0 and `reason_o` is 0. All of them are 0 after reset.
- R2: Word layout and length. Word 0 is the header version. Word 3 is the signature, word 4 the header checksum, word 5 the loader version, word 6 the platform-flag mask, word 7 the payload size in bytes and word 8 the total size in bytes. The header is 12 words (48 bytes). If the last word is not word number total/4 − 1 (counting from 0), or if the stream ends inside the header, the reason is 7 (length mismatch). This code has the highest priority.
- R3: If 48 plus the payload size exceeds the total size, the reason is 1. This code is second in priority.
- R4: If the loader version is not 1, or the header version differs from `hdr_type_i`, the reason is 2. This code is third in priority.
- R5: A payload size field of 0 selects a payload of `DEF_DATA_BYTES` and a total of `DEF_DATA_BYTES` + 48. In that case the total size field is ignored.
- R6: The extended table takes up the bytes from 48 + payload up to the total size. Its first word is an entry count, its second word a table checksum, and three spare words follow. After those come entries of (signature, flags, checksum). If the table has a nonzero size that is not count × 12 + 20, the reason is 3. This covers tables shorter than 20 bytes and sizes that leave a partial entry.
- R7: If the table is present and the wrapping sum of all its words is not zero, the reason is 4.
- R8: If the wrapping sum of all header and payload words is not zero, the reason is 5.
- R9: For each table entry, the header's signature + flags + checksum minus the entry's signature + flags + checksum must be zero. Otherwise the reason is 6. This code has the lowest priority.
- R10: `pass_o` is 1 exactly when the reason is 0. `match_o` is 1 only when the image passes and either the header signature or some table entry matches. A match needs equal signatures and flag masks that are both zero or share a set bit.
- R11: The next image may begin in the cycle right after a last word. Its sums, captured fields and entry checks start from clean state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_type_i | input | 32 | Expected header version |
| cpu_sig_i | input | 32 | Processor signature to match |
| cpu_pf_i | input | 32 | Processor platform-flag mask |
| in_valid_i | input | 1 | Stream word valid |
| in_data_i | input | 32 | Stream word |
| in_last_i | input | 1 | Final word of the image |
| done_o | output | 1 | One-cycle result strobe |
| pass_o | output | 1 | Image passed all checks |
| match_o | output | 1 | Image passed and a signature matched |
| reason_o | output | 3 | Failure code, 0 when passing |

## Verification
Each result is due exactly one clock after the rising edge that accepts the last word. That includes a match found in the very last table entry and any sum that the last word completes. The monitor samples on every falling edge. When `done_o` is high it takes the oldest expected result and compares all three fields. In every other cycle it checks that the outputs are quiet. The driver changes the identity or header-type inputs only after the idle gap that follows an image, so that the pulse for that image has already been sampled. Back-to-back images, sent with no gap, check that the expected results come out in order.

// File: rtl/ucv_pkg.sv
`timescale 1ns/1ps
package ucv_pkg;
    localparam int unsigned HDR_WORDS     = 12;
    localparam int unsigned HDR_BYTES     = HDR_WORDS * 4;
    localparam int unsigned EXT_HDR_WORDS = 5;
    localparam int unsigned EXT_HDR_BYTES = EXT_HDR_WORDS * 4;
    localparam int unsigned ENT_BYTES     = 12;

    // header word positions decoded by the block
    localparam int unsigned F_HVER = 0;
    localparam int unsigned F_SIG  = 3;
    localparam int unsigned F_CK   = 4;
    localparam int unsigned F_LVER = 5;
    localparam int unsigned F_PF   = 6;
    localparam int unsigned F_DSZ  = 7;
    localparam int unsigned F_TSZ  = 8;

    typedef enum logic [2:0] {
        RSN_OK      = 3'd0,
        RSN_SIZE    = 3'd1,
        RSN_VER     = 3'd2,
        RSN_LAYOUT  = 3'd3,
        RSN_EXTSUM  = 3'd4,
        RSN_MAINSUM = 3'd5,
        RSN_XCHK    = 3'd6,
        RSN_TRUNC   = 3'd7
    } reason_e;
endpackage

// File: rtl/ucv_sig_match.sv
`timescale 1ns/1ps
module ucv_sig_match (
    input  logic [31:0] sig_a_i,
    input  logic [31:0] pf_a_i,
    input  logic [31:0] sig_b_i,
    input  logic [31:0] pf_b_i,
    output logic        hit_o
);
    logic both_zero;
    logic overlap;

    always_comb begin
        both_zero = (pf_a_i == '0) && (pf_b_i == '0);
        overlap   = |(pf_a_i & pf_b_i);
        hit_o     = (sig_a_i == sig_b_i) && (both_zero || overlap);
    end
endmodule

// File: rtl/ucv_ext_tracker.sv
`timescale 1ns/1ps
module ucv_ext_tracker (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fire_i,
    input  logic        clr_i,
    input  logic [31:0] word_i,
    input  logic [31:0] main3_i,
    input  logic [31:0] cpu_sig_i,
    input  logic [31:0] cpu_pf_i,
    output logic        bad_o,
    output logic        hit_o
);
    typedef struct packed {
        logic [1:0]  phase;
        logic [31:0] sig;
        logic [31:0] pf;
        logic        bad;
        logic        hit;
    } trk_t;

    trk_t trk_q, walk_d, trk_d;
    logic ent_hit;

    ucv_sig_match u_ent_match (
        .sig_a_i (trk_q.sig),
        .pf_a_i  (trk_q.pf),
        .sig_b_i (cpu_sig_i),
        .pf_b_i  (cpu_pf_i),
        .hit_o   (ent_hit)
    );

    always_comb begin
        walk_d = trk_q;
        if (fire_i) begin
            case (trk_q.phase)
                2'd0: begin
                    walk_d.sig   = word_i;
                    walk_d.phase = 2'd1;
                end
                2'd1: begin
                    walk_d.pf    = word_i;
                    walk_d.phase = 2'd2;
                end
                default: begin
                    walk_d.bad   = trk_q.bad |
                                   (main3_i != (trk_q.sig + trk_q.pf + word_i));
                    walk_d.hit   = trk_q.hit | ent_hit;
                    walk_d.phase = 2'd0;
                end
            endcase
        end
        trk_d = clr_i ? '0 : walk_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign bad_o = walk_d.bad;
    assign hit_o = walk_d.hit;

    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.phase != 2'd3); // R9
    AST_TRK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (trk_q.phase == 2'd0) && !trk_q.bad && !trk_q.hit); // R11
endmodule

// File: rtl/ucode_chk_top.sv
`timescale 1ns/1ps
module ucode_chk_top
    import ucv_pkg::*;
#(
    parameter int unsigned DEF_DATA_BYTES = 2000,
    parameter int unsigned LDR_VER        = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] hdr_type_i,
    input  logic [31:0] cpu_sig_i,
    input  logic [31:0] cpu_pf_i,
    input  logic        in_valid_i,
    input  logic [31:0] in_data_i,
    input  logic        in_last_i,
    output logic        done_o,
    output logic        pass_o,
    output logic        match_o,
    output logic [2:0]  reason_o
);
    localparam logic [33:0] DEF_DATA  = 34'(DEF_DATA_BYTES);
    localparam logic [33:0] HDR_B     = 34'(HDR_BYTES);
    localparam logic [33:0] DEF_TOTAL = DEF_DATA + HDR_B;

    typedef struct packed {
        logic [31:0] idx;
        logic [31:0] hver;
        logic [31:0] lver;
        logic [31:0] sig;
        logic [31:0] pf;
        logic [31:0] ck;
        logic [31:0] dsz;
        logic [31:0] tsz;
        logic [31:0] msum;
        logic [31:0] esum;
        logic [31:0] ecnt;
        logic        done;
        logic        pass;
        logic        match;
        reason_e     reason;
    } st_t;

    st_t st_q, st_d;

    logic        end_beat;
    logic [33:0] eff_data, eff_total, main_words, total_words, idx_w, ext_pos, ext_bytes;
    logic        in_main, in_ext, ent_fire, has_ext;
    logic [31:0] msum_now, esum_now, ecnt_now, main3;
    logic        size_bad, layout_bad, ver_bad, trunc;
    logic        x_bad, x_hit, main_hit;
    reason_e     rsn;

    // region decode from captured header fields
    always_comb begin
        end_beat    = in_valid_i && in_last_i;
        eff_data    = (st_q.dsz == '0) ? DEF_DATA  : {2'b00, st_q.dsz};
        eff_total   = (st_q.dsz == '0) ? DEF_TOTAL : {2'b00, st_q.tsz};
        main_words  = (HDR_B + eff_data) >> 2;
        total_words = eff_total >> 2;
        idx_w       = {2'b00, st_q.idx};
        in_main     = (idx_w < 34'(HDR_WORDS)) || (idx_w < main_words);
        in_ext      = !in_main && (idx_w < total_words);
        ext_pos     = idx_w - main_words;
        ent_fire    = in_valid_i && in_ext && (ext_pos >= 34'(EXT_HDR_WORDS));
        msum_now    = st_q.msum + ((in_valid_i && in_main) ? in_data_i : 32'd0);
        esum_now    = st_q.esum + ((in_valid_i && in_ext)  ? in_data_i : 32'd0);
        ecnt_now    = (in_valid_i && in_ext && ext_pos == '0) ? in_data_i : st_q.ecnt;
        main3       = st_q.sig + st_q.pf + st_q.ck;
    end

    ucv_ext_tracker u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_i    (ent_fire),
        .clr_i     (end_beat),
        .word_i    (in_data_i),
        .main3_i   (main3),
        .cpu_sig_i (cpu_sig_i),
        .cpu_pf_i  (cpu_pf_i),
        .bad_o     (x_bad),
        .hit_o     (x_hit)
    );

    ucv_sig_match u_main_match (
        .sig_a_i (st_q.sig),
        .pf_a_i  (st_q.pf),
        .sig_b_i (cpu_sig_i),
        .pf_b_i  (cpu_pf_i),
        .hit_o   (main_hit)
    );

    // verdict, in priority order
    always_comb begin
        size_bad   = (HDR_B + eff_data) > eff_total;
        ext_bytes  = eff_total - HDR_B - eff_data;
        has_ext    = (ext_bytes != '0);
        layout_bad = has_ext &&
                     ({2'b00, ext_bytes} != ({4'b0000, ecnt_now} * 36'(ENT_BYTES)
                                             + 36'(EXT_HDR_BYTES)));
        ver_bad    = (st_q.lver != LDR_VER) || (st_q.hver != hdr_type_i);
        trunc      = (st_q.idx < 32'(HDR_WORDS - 1)) || ((idx_w + 34'd1) != total_words);
        if (trunc)                           rsn = RSN_TRUNC;
        else if (size_bad)                   rsn = RSN_SIZE;
        else if (ver_bad)                    rsn = RSN_VER;
        else if (layout_bad)                 rsn = RSN_LAYOUT;
        else if (has_ext && esum_now != '0)  rsn = RSN_EXTSUM;
        else if (msum_now != '0)             rsn = RSN_MAINSUM;
        else if (has_ext && x_bad)           rsn = RSN_XCHK;
        else                                 rsn = RSN_OK;
    end

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.pass   = 1'b0;
        st_d.match  = 1'b0;
        st_d.reason = RSN_OK;
        if (in_valid_i) begin
            case (st_q.idx)
                32'(F_HVER): st_d.hver = in_data_i;
                32'(F_SIG):  st_d.sig  = in_data_i;
                32'(F_CK):   st_d.ck   = in_data_i;
                32'(F_LVER): st_d.lver = in_data_i;
                32'(F_PF):   st_d.pf   = in_data_i;
                32'(F_DSZ):  st_d.dsz  = in_data_i;
                32'(F_TSZ):  st_d.tsz  = in_data_i;
                default: ;
            endcase
            st_d.msum = msum_now;
            st_d.esum = esum_now;
            st_d.ecnt = ecnt_now;
            st_d.idx  = (&st_q.idx) ? st_q.idx : st_q.idx + 32'd1;
            if (in_last_i) begin
                st_d        = '0;
                st_d.done   = 1'b1;
                st_d.reason = rsn;
                st_d.pass   = (rsn == RSN_OK);
                st_d.match  = (rsn == RSN_OK) && (main_hit || (has_ext && x_hit));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o   = st_q.done;
    assign pass_o   = st_q.pass;
    assign match_o  = st_q.match;
    assign reason_o = st_q.reason;

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(end_beat)); // R1
    AST_LAST_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        end_beat |=> done_o); // R1
    AST_QUIET_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (!pass_o && !match_o && reason_o == 3'd0)); // R1
    AST_MATCH_NEEDS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> pass_o); // R10
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        end_beat |=> (st_q.idx == '0 && st_q.msum == '0 && st_q.esum == '0)); // R11
endmodule

// File: tb/ucode_chk_top_tb.sv
`timescale 1ns/1ps
module ucode_chk_top_tb;
    localparam int DEF_DATA = 16;
    localparam logic [31:0] SIG = 32'h000A_06C1;
    localparam logic [31:0] PF  = 32'h0000_0004;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] hdr_type_i, cpu_sig_i, cpu_pf_i, in_data_i;
    logic in_valid_i, in_last_i;
    logic done_o, pass_o, match_o;
    logic [2:0] reason_o;

    always #4 clk = ~clk;

    ucode_chk_top #(.DEF_DATA_BYTES(DEF_DATA)) u_dut (
        .clk(clk), .rst_n(rst_n), .hdr_type_i(hdr_type_i), .cpu_sig_i(cpu_sig_i),
        .cpu_pf_i(cpu_pf_i), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
        .in_last_i(in_last_i), .done_o(done_o), .pass_o(pass_o), .match_o(match_o),
        .reason_o(reason_o)
    );

    int checks = 0;
    int fails = 0;

    typedef struct {
        logic       p;
        logic       m;
        logic [2:0] r;
        string      tag;
    } exp_t;

    exp_t expq[$];
    exp_t cur;
    logic [31:0] img[$];
    int ext_at;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic exp_t mk(input logic p, input logic m, input logic [2:0] r,
                                input string t);
        exp_t e;
        e.p = p; e.m = m; e.r = r; e.tag = t;
        return e;
    endfunction

    task automatic fix_main(input int mw);
        logic [31:0] s = 32'd0;
        for (int i = 0; i < mw; i++) if (i != 4) s += img[i];
        img[4] = 32'd0 - s;
    endtask

    task automatic fix_ext();
        logic [31:0] s = 32'd0;
        for (int i = ext_at; i < img.size(); i++) if (i != ext_at + 1) s += img[i];
        img[ext_at + 1] = 32'd0 - s;
    endtask

    task automatic build(input int dw, input int nent, input logic [31:0] hsig,
                         input logic [31:0] hpf, input logic [31:0] es0, input logic [31:0] ep0,
                         input logic [31:0] es1, input logic [31:0] ep1);
        int dsz = dw * 4;
        int eb = (nent > 0) ? 20 + 12 * nent : 0;
        logic [31:0] m3, s, p;
        img.delete();
        img.push_back(32'd1);           img.push_back(32'h0000_0015);
        img.push_back(32'h0607_2023);   img.push_back(hsig);
        img.push_back(32'd0);           img.push_back(32'd1);
        img.push_back(hpf);             img.push_back(32'(dsz));
        img.push_back(32'(48 + dsz + eb));
        img.push_back(32'd0); img.push_back(32'd0); img.push_back(32'd0);
        for (int i = 0; i < dw; i++) img.push_back(32'h3C5A_0000 + 32'(i) * 32'h0101);
        fix_main(12 + dw);
        ext_at = 12 + dw;
        if (nent > 0) begin
            m3 = hsig + hpf + img[4];
            img.push_back(32'(nent));
            for (int i = 0; i < 4; i++) img.push_back(32'd0);
            for (int k = 0; k < nent; k++) begin
                s = (k == 0) ? es0 : es1;
                p = (k == 0) ? ep0 : ep1;
                img.push_back(s); img.push_back(p); img.push_back(m3 - s - p);
            end
            fix_ext();
        end
    endtask

    task automatic send(input exp_t e, input int n, input bit gap);
        expq.push_back(e);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid_i = 1'b1;
            in_data_i  = img[i];
            in_last_i  = (i == n - 1);
        end
        if (gap) begin
            @(negedge clk);
            in_valid_i = 1'b0; in_last_i = 1'b0; in_data_i = 32'd0;
            repeat (3) @(negedge clk);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                if (expq.size() == 0) begin
                    check("R1", "unexpected done", 32'd1, 32'd0);
                end else begin
                    cur = expq.pop_front();
                    check(cur.tag, "pass",   32'(pass_o),   32'(cur.p));
                    check(cur.tag, "match",  32'(match_o),  32'(cur.m));
                    check(cur.tag, "reason", 32'(reason_o), 32'(cur.r));
                end
            end else begin
                check("R1", "quiet outputs", {29'd0, pass_o, match_o, |reason_o}, 32'd0);
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        in_valid_i = 1'b0; in_last_i = 1'b0; in_data_i = 32'd0;
        hdr_type_i = 32'd1; cpu_sig_i = SIG; cpu_pf_i = PF;
        repeat (3) @(negedge clk);
        check("R1", "reset done",   32'(done_o),   32'd0);
        check("R1", "reset pass",   32'(pass_o),   32'd0);
        check("R1", "reset reason", 32'(reason_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 R10 basic pass and match
        build(4, 0, SIG, PF, 0, 0, 0, 0);
        send(mk(1, 1, 3'd0, "R8"), img.size(), 1);
        build(4, 0, SIG + 1, PF, 0, 0, 0, 0);
        send(mk(1, 0, 3'd0, "R10 sig differs"), img.size(), 1);
        build(4, 0, SIG, 32'h3, 0, 0, 0, 0);
        send(mk(1, 0, 3'd0, "R10 flags disjoint"), img.size(), 1);
        cpu_pf_i = 32'd0;
        build(4, 0, SIG, 32'd0, 0, 0, 0, 0);
        send(mk(1, 1, 3'd0, "R10 flags both zero"), img.size(), 1);
        build(4, 0, SIG, PF, 0, 0, 0, 0);
        send(mk(1, 0, 3'd0, "R10 one flag mask zero"), img.size(), 1);
        cpu_pf_i = PF;

        // extended table
        build(4, 2, SIG + 5, PF, 32'h1111, PF, SIG, 32'h6);
        send(mk(1, 1, 3'd0, "R10 entry match"), img.size(), 1);
        build(4, 2, SIG + 5, PF, 32'h1111, PF, SIG, 32'h1);
        send(mk(1, 0, 3'd0, "R10 no entry match"), img.size(), 1);
        build(4, 2, SIG + 5, PF, 32'h1111, PF, SIG, 32'h6);
        img[ext_at + 7] ^= 32'h10; fix_ext();
        send(mk(0, 0, 3'd6, "R9"), img.size(), 1);
        build(4, 2, SIG + 5, PF, 32'h1111, PF, SIG, 32'h6);
        img[ext_at + 2] = 32'h77;
        send(mk(0, 0, 3'd4, "R7"), img.size(), 1);
        build(4, 2, SIG + 5, PF, 32'h1111, PF, SIG, 32'h6);
        img[ext_at] = 32'd3; fix_ext();
        send(mk(0, 0, 3'd3, "R6 count"), img.size(), 1);
        build(4, 0, SIG, PF, 0, 0, 0, 0);
        img[8] = 32'd72; fix_main(16);
        img.push_back(32'd0); img.push_back(32'd0);
        send(mk(0, 0, 3'd3, "R6 short table"), img.size(), 1);

        // header checks
        build(4, 0, SIG, PF, 0, 0, 0, 0);
        img[13] ^= 32'd1;
        send(mk(0, 0, 3'd5, "R8"), img.size(), 1);
        build(4, 0, SIG, PF, 0, 0, 0, 0);
        img[5] = 32'd2; fix_main(16);
        send(mk(0, 0, 3'd2, "R4 loader"), img.size(), 1);
        build(4, 0, SIG, PF, 0, 0, 0, 0);
        img[0] = 32'd3; fix_main(16);
        send(mk(0, 0, 3'd2, "R4 type"), img.size(), 1);
        hdr_type_i = 32'd3;
        send(mk(1, 1, 3'd0, "R4 type agrees"), img.size(), 1);
        hdr_type_i = 32'd1;
        build(4, 0, SIG, PF, 0, 0, 0, 0);
        img[8] = 32'd60; fix_main(16);
        send(mk(0, 0, 3'd1, "R3"), 15, 1);

        // length
        build(4, 0, SIG, PF, 0, 0, 0, 0);
        send(mk(0, 0, 3'd7, "R2 short"), 15, 1);
        send(mk(0, 0, 3'd7, "R2 in header"), 5, 1);
        img.push_back(32'd0);
        send(mk(0, 0, 3'd7, "R2 long"), img.size(), 1);

        // default sizes
        build(4, 0, SIG, PF, 0, 0, 0, 0);
        img[7] = 32'd0; img[8] = 32'h1234; fix_main(16);
        send(mk(1, 1, 3'd0, "R5"), img.size(), 1);

        // back to back
        build(4, 0, SIG, PF, 0, 0, 0, 0);
        img[14] ^= 32'h100;
        send(mk(0, 0, 3'd5, "R11 first"), img.size(), 0);
        build(4, 0, SIG, PF, 0, 0, 0, 0);
        send(mk(1, 1, 3'd0, "R11 second"), img.size(), 0);
        build(4, 2, SIG + 5, PF, 32'h1111, PF, SIG, 32'h6);
        send(mk(1, 1, 3'd0, "R11 third"), img.size(), 1);

        repeat (5) @(negedge clk);
        check("R1", "pending results", 32'(expq.size()), 32'd0);
        finish_run();
    end
endmodule